// File: doc/BRIEF.md
# Dense to Compressed-Row Matrix Encoder

The encoder takes a small dense matrix that arrives one element per accepted beat, scanned row by row from the top and, inside each row, from the leftmost column. Every element that is not zero is written to a value store and a column store at the next free slot, and slots are filled in arrival order. At the first element of each row, the encoder writes that slot number to a row-offset store. A row with no stored elements therefore leaves the same offset as the row after it. One cycle after the final element, the encoder writes a closing offset, equal to the total number of stored elements, at the entry past the last row. In the same cycle it pulses a completion flag.

The three stores are kept outside the block. The encoder drives their write ports: a shared slot address with value and column data, and a separate row-offset port. The input uses a valid/ready handshake. Ready stays high except in the single completion cycle, when the row-offset port carries the closing write. The value store holds a fixed number of slots. A non-zero element that finds the stores full is not written, and it raises an overflow flag that stays set until the next matrix begins.

Top module: `crs_encoder`

## Requirements
- R1: After reset, `done`, `overflow`, `val_we` and `ptr_we` are 0, `nnz_count` is 0 and `in_ready` is 1.
- R2: Each accepted element with a value other than zero raises `val_we` in its acceptance cycle. The write carries the element value on `val_data`, and `val_addr` counts 0, 1, 2, … across the matrix. An element equal to zero causes no value write.
- R3: With each value write, `col_data` carries the element's column: 0 for the element marked `in_row_start`, and one more for each later element of that row.
- R4: An accepted element marked `in_row_start` raises `ptr_we` in the same cycle. `ptr_addr` is the row number (0 for the first row-start of a matrix, counting up), and `ptr_data` is the number of value writes made earlier in this matrix.
- R5: The row-offset entry at address 0 is always written as 0.
- R6: `done` is high for exactly one cycle, the cycle after the element marked `in_last` is accepted. In that cycle `ptr_we` is 1, `ptr_addr` equals ROWS, `ptr_data` equals the total number of stored elements, and `in_ready` is 0. In all other cycles `in_ready` is 1.
- R7: While `done` is high, `nnz_count` equals the number of elements stored for the matrix.
- R8: A row whose elements are all zero gets the same offset value as the following row.
- R9: Once NNZ_MAX elements are stored, a further non-zero element causes no write and sets `overflow`. The count stays at NNZ_MAX, and `val_addr` never reaches NNZ_MAX.
- R10: The first element accepted after `done` starts a new matrix. Slot and row numbering restart at 0, and `overflow` returns to 0.
- R11: A cycle without an accepted element, other than the completion cycle, produces no value write and no row-offset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element beat present |
| in_ready | output | 1 | Encoder takes the beat; low only in the completion cycle |
| in_data | input | DW | Element value |
| in_row_start | input | 1 | Beat is the first element of a row |
| in_last | input | 1 | Beat is the final element of the matrix |
| val_we | output | 1 | Value/column store write enable |
| val_addr | output | $clog2(NNZ_MAX+1) | Slot written in both value and column stores |
| val_data | output | DW | Value to store |
| col_data | output | max(1,$clog2(COLS)) | Column to store |
| ptr_we | output | 1 | Row-offset store write enable |
| ptr_addr | output | $clog2(ROWS+1) | Row-offset entry |
| ptr_data | output | $clog2(NNZ_MAX+1) | Offset value |
| done | output | 1 | One-cycle completion pulse |
| nnz_count | output | $clog2(NNZ_MAX+1) | Elements stored so far / total at completion |
| overflow | output | 1 | A non-zero element found the stores full |

## Verification
Value, column and row-start offset writes are combinational from the accepted beat. The bench sets each beat one nanosecond after a falling edge and reads these write ports in that same half cycle, before the rising edge that takes the beat. The completion pulse, the closing offset, the count and the overflow flag come from registers loaded at the edge that takes the last beat. They are read one falling edge later, and the pulse is read again one cycle after that to show it has fallen. Idle beats with random side inputs are mixed in, and both write enables are checked to stay low during them.

// File: rtl/crs_pkg.sv
`timescale 1ns/1ps
package crs_pkg;
  // How one accepted element is handled by the slot counter.
  typedef enum logic [1:0] {
    EL_SKIP  = 2'd0,  // zero value, dropped
    EL_STORE = 2'd1,  // non-zero, free slot available
    EL_SPILL = 2'd2   // non-zero, stores already full
  } el_class_e;
endpackage

// File: rtl/crs_elem_filter.sv
`timescale 1ns/1ps
module crs_elem_filter
  import crs_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NNZ_MAX = 16,
  localparam int KW     = $clog2(NNZ_MAX + 1)
) (
  input  logic [DW-1:0] data,
  input  logic [KW-1:0] slot,
  output el_class_e     cls
);
  function automatic logic is_zero(input logic [DW-1:0] v);
    return v == '0;
  endfunction

  function automatic logic is_full(input logic [KW-1:0] s);
    return s == KW'(NNZ_MAX);
  endfunction

  always_comb begin
    if (is_zero(data))      cls = EL_SKIP;
    else if (is_full(slot)) cls = EL_SPILL;
    else                    cls = EL_STORE;
  end
endmodule

// File: rtl/crs_index_ctr.sv
`timescale 1ns/1ps
module crs_index_ctr
  import crs_pkg::*;
#(
  parameter int NNZ_MAX = 16,
  localparam int KW     = $clog2(NNZ_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          fresh,
  input  el_class_e     cls,
  output logic [KW-1:0] slot_cur,
  output logic [KW-1:0] slot_q,
  output logic          ovf_q
);
  logic ovf_cur;

  function automatic logic [KW-1:0] bump(input logic [KW-1:0] s, input logic inc);
    return s + KW'(inc);
  endfunction

  assign slot_cur = fresh ? '0 : slot_q;
  assign ovf_cur  = fresh ? 1'b0 : ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      ovf_q  <= 1'b0;
    end else if (accept) begin
      slot_q <= bump(slot_cur, cls == EL_STORE);
      ovf_q  <= ovf_cur | (cls == EL_SPILL);
    end
  end
endmodule

// File: rtl/crs_pos_track.sv
`timescale 1ns/1ps
module crs_pos_track #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  localparam int RW   = $clog2(ROWS + 1),
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          fresh,
  input  logic          row_start,
  output logic [RW-1:0] row_cur,
  output logic [CW-1:0] col_cur
);
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;

  assign row_cur = fresh ? '0 : row_q;
  assign col_cur = row_start ? '0 : col_q + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (accept) begin
      row_q <= row_start ? row_cur + RW'(1) : row_cur;
      col_q <= col_cur;
    end
  end
endmodule

// File: rtl/crs_encoder.sv
`timescale 1ns/1ps
module crs_encoder
  import crs_pkg::*;
#(
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  parameter int DW      = 8,
  parameter int NNZ_MAX = 16,
  localparam int KW     = $clog2(NNZ_MAX + 1),
  localparam int RW     = $clog2(ROWS + 1),
  localparam int CW     = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_row_start,
  input  logic          in_last,
  output logic          val_we,
  output logic [KW-1:0] val_addr,
  output logic [DW-1:0] val_data,
  output logic [CW-1:0] col_data,
  output logic          ptr_we,
  output logic [RW-1:0] ptr_addr,
  output logic [KW-1:0] ptr_data,
  output logic          done,
  output logic [KW-1:0] nnz_count,
  output logic          overflow
);
  // Named internal events, visible to the bound checker.
  logic          accept;
  logic          fresh_q;
  logic          done_q;
  el_class_e     cls;
  logic [KW-1:0] slot_cur;
  logic [KW-1:0] slot_q;
  logic          ovf_q;
  logic [RW-1:0] row_cur;
  logic [CW-1:0] col_cur;

  assign in_ready = ~done_q;
  assign accept   = in_valid & in_ready;

  crs_elem_filter #(.DW(DW), .NNZ_MAX(NNZ_MAX)) u_filter (
    .data (in_data),
    .slot (slot_cur),
    .cls  (cls)
  );

  crs_index_ctr #(.NNZ_MAX(NNZ_MAX)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .fresh    (fresh_q),
    .cls      (cls),
    .slot_cur (slot_cur),
    .slot_q   (slot_q),
    .ovf_q    (ovf_q)
  );

  crs_pos_track #(.ROWS(ROWS), .COLS(COLS)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .fresh     (fresh_q),
    .row_start (in_row_start),
    .row_cur   (row_cur),
    .col_cur   (col_cur)
  );

  // fresh_q: next accepted beat opens a new matrix.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= accept & in_last;
      if (accept) fresh_q <= in_last;
    end
  end

  assign val_we   = accept & (cls == EL_STORE);
  assign val_addr = slot_cur;
  assign val_data = in_data;
  assign col_data = col_cur;

  // Closing offset owns the port in the completion cycle (no beat accepted then).
  assign ptr_we   = (accept & in_row_start) | done_q;
  assign ptr_addr = done_q ? RW'(ROWS) : row_cur;
  assign ptr_data = done_q ? slot_q : slot_cur;

  assign done      = done_q;
  assign nnz_count = slot_q;
  assign overflow  = ovf_q;
endmodule

// File: rtl/crs_encoder_chk.sv
`timescale 1ns/1ps
module crs_encoder_chk #(
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  parameter int DW      = 8,
  parameter int NNZ_MAX = 16,
  localparam int KW     = $clog2(NNZ_MAX + 1),
  localparam int RW     = $clog2(ROWS + 1),
  localparam int CW     = (COLS > 1) ? $clog2(COLS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          val_we,
  input logic [KW-1:0] val_addr,
  input logic          ptr_we,
  input logic [RW-1:0] ptr_addr,
  input logic [KW-1:0] ptr_data,
  input logic          done,
  input logic [KW-1:0] nnz_count,
  input logic          overflow
);
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> done);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_low_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  p_closing_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ptr_we && ptr_addr == RW'(ROWS) && ptr_data == nnz_count));

  p_first_offset_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && !done && ptr_addr == '0) |-> ptr_data == '0);

  p_slot_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    val_we |-> val_addr < KW'(NNZ_MAX));

  p_overflow_at_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> nnz_count == KW'(NNZ_MAX));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !done) |-> (!val_we && !ptr_we));
endmodule

bind crs_encoder crs_encoder_chk #(
  .ROWS(ROWS), .COLS(COLS), .DW(DW), .NNZ_MAX(NNZ_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .val_we    (val_we),
  .val_addr  (val_addr),
  .ptr_we    (ptr_we),
  .ptr_addr  (ptr_addr),
  .ptr_data  (ptr_data),
  .done      (done),
  .nnz_count (nnz_count),
  .overflow  (overflow)
);

// File: tb/tb_crs_encoder.sv
`timescale 1ns/1ps
module tb_crs_encoder;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int DW   = 8;
  localparam int NNZ  = 10;
  localparam int KW   = $clog2(NNZ + 1);
  localparam int RW   = $clog2(ROWS + 1);
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, in_row_start, in_last;
  logic [DW-1:0] in_data;
  logic          val_we, ptr_we, done, overflow;
  logic [KW-1:0] val_addr, ptr_data, nnz_count;
  logic [DW-1:0] val_data;
  logic [CW-1:0] col_data;
  logic [RW-1:0] ptr_addr;

  always #4 clk = ~clk;

  crs_encoder #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .NNZ_MAX(NNZ)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_row_start(in_row_start), .in_last(in_last),
    .val_we(val_we), .val_addr(val_addr), .val_data(val_data), .col_data(col_data),
    .ptr_we(ptr_we), .ptr_addr(ptr_addr), .ptr_data(ptr_data),
    .done(done), .nnz_count(nnz_count), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int mat [ROWS][COLS];
  int exp_val [NNZ];
  int exp_col [NNZ];
  int exp_ptr [ROWS+1];
  int exp_k;
  int exp_ovf;
  int cap_val [NNZ];
  int cap_col [NNZ];
  int cap_ptr [ROWS+1];
  int wcount, pcount;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference: walk the dense matrix, keep non-zeros up to the slot limit.
  task automatic build_expected();
    int k = 0;
    exp_ovf = 0;
    for (int r = 0; r < ROWS; r++) begin
      exp_ptr[r] = k;
      for (int c = 0; c < COLS; c++) begin
        if (mat[r][c] != 0) begin
          if (k < NNZ) begin
            exp_val[k] = mat[r][c];
            exp_col[k] = c;
            k++;
          end else exp_ovf = 1;
        end
      end
    end
    exp_ptr[ROWS] = k;
    exp_k = k;
  endtask

  task automatic capture();
    if (val_we) begin
      chk("R2", "slot address order", int'(val_addr), wcount);
      if (wcount < NNZ) begin
        cap_val[wcount] = int'(val_data);
        cap_col[wcount] = int'(col_data);
      end
      wcount++;
    end
    if (ptr_we) begin
      if (int'(ptr_addr) <= ROWS) cap_ptr[ptr_addr] = int'(ptr_data);
      pcount++;
    end
  endtask

  task automatic run_matrix(int gap_pct);
    build_expected();
    wcount = 0;
    pcount = 0;
    for (int i = 0; i <= ROWS; i++) cap_ptr[i] = -1;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        while (int'($urandom_range(99)) < gap_pct) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_data = DW'($urandom);
          in_row_start = 1'($urandom);
          in_last = 1'($urandom);
          #1;
          chk("R11", "idle val_we", int'(val_we), 0);
          chk("R11", "idle ptr_we", int'(ptr_we), 0);
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data = DW'(mat[r][c]);
        in_row_start = (c == 0);
        in_last = (r == ROWS-1) && (c == COLS-1);
        #1;
        chk("R6", "ready while busy", int'(in_ready), 1);
        chk("R2", "zero element not written", int'(val_we),
            (mat[r][c] != 0 && wcount < NNZ) ? 1 : 0);
        capture();
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
    in_row_start = 1'b0;
    #1;
    chk("R6", "done after last", int'(done), 1);
    chk("R6", "ready low at done", int'(in_ready), 0);
    chk("R7", "nnz_count at done", int'(nnz_count), exp_k);
    chk("R9", "overflow flag", int'(overflow), exp_ovf);
    capture();
    @(negedge clk);
    #1;
    chk("R6", "done one cycle", int'(done), 0);
    chk("R2", "value writes", wcount, exp_k);
    for (int i = 0; i < exp_k; i++) begin
      chk("R2", "stored value", cap_val[i], exp_val[i]);
      chk("R3", "stored column", cap_col[i], exp_col[i]);
    end
    chk("R4", "offset writes", pcount, ROWS + 1);
    chk("R5", "offset entry 0", cap_ptr[0], 0);
    for (int i = 1; i < ROWS; i++) chk("R4", "row offset", cap_ptr[i], exp_ptr[i]);
    chk("R6", "closing offset", cap_ptr[ROWS], exp_k);
  endtask

  task automatic fill(int dens);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        mat[r][c] = (int'($urandom_range(99)) < dens) ? int'($urandom_range(255, 1)) : 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      chk("R6", "watchdog completion", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    in_row_start = 1'b0;
    in_last = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset done", int'(done), 0);
    chk("R1", "reset overflow", int'(overflow), 0);
    chk("R1", "reset nnz_count", int'(nnz_count), 0);
    chk("R1", "reset val_we", int'(val_we), 0);
    chk("R1", "reset ptr_we", int'(ptr_we), 0);
    chk("R1", "reset ready", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: nine non-zeros, offsets 0,2,4,7,9.
    mat = '{'{3, 4, 0, 0}, '{0, 5, 9, 0}, '{2, 0, 7, 6}, '{0, 8, 0, 1}};
    run_matrix(0);
    chk("R4", "example offset row 2", cap_ptr[2], 4);
    chk("R4", "example offset row 3", cap_ptr[3], 7);

    // Directed: empty rows repeat offsets (R8).
    mat = '{'{0, 1, 0, 2}, '{0, 0, 0, 0}, '{5, 0, 0, 0}, '{0, 0, 0, 0}};
    run_matrix(20);
    chk("R8", "empty row 1 repeats", cap_ptr[1], cap_ptr[2]);
    chk("R8", "empty row 3 repeats", cap_ptr[3], cap_ptr[4]);

    // Directed: all zero.
    mat = '{default: '{default: 0}};
    run_matrix(0);

    // Directed: exactly NNZ non-zeros, no overflow.
    mat = '{'{1, 2, 3, 0}, '{4, 5, 0, 0}, '{6, 7, 8, 0}, '{9, 10, 0, 0}};
    run_matrix(10);
    chk("R9", "full without spill", int'(overflow), 0);

    // Directed: fully dense, spills past NNZ (R9).
    mat = '{default: '{default: 7}};
    run_matrix(0);
    chk("R9", "count capped", int'(nnz_count), NNZ);

    // Next matrix restarts numbering and clears overflow (R10).
    mat = '{'{0, 0, 9, 0}, '{0, 0, 0, 0}, '{0, 3, 0, 0}, '{0, 0, 0, 0}};
    run_matrix(0);
    chk("R10", "overflow cleared", int'(overflow), 0);
    chk("R10", "first slot value", cap_val[0], 9);

    for (int n = 0; n < 24; n++) begin
      fill(int'($urandom_range(100)));
      run_matrix(30);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule